// File: doc/BRIEF.md
# Open-Row Bank Command Sequencer

This block turns memory requests for one DRAM bank into the command stream a controller places on the command bus. It is built for an open-row policy. The block keeps track of which row the bank holds in its row buffer. It never closes that row on its own initiative.

A request carries a read/write flag, a row and a column, and it is accepted through a valid/ready handshake. There are three cases:
- If the request targets the row already open, the block issues a single column command.
- If the request targets a different row, the block issues three commands in order: close the row, open the new row, then the column command.
- After reset no row is open. The first request therefore needs only the open command and the column command.

Each column command moves one 64-byte line as an 8-beat burst on a 64-bit data path, so one request always maps to exactly one read or write command. An external timing tracker gates every command through a bank-ready input. A sticky flag reports whether the most recently accepted request hit the open row.

Top module: `bank_cmd_sequencer`

## Requirements
- R1: While reset is asserted (rstN low), reqReady is 1, cmdValid is 0 and lastHit is 0. No row is considered open after reset.
- R2: cmdCode takes only four values: 0 = precharge, 1 = activate, 2 = read, 3 = write. No refresh or auto-precharge variant exists.
- R3: The first request after reset produces exactly two commands: activate with the request's row, then the column command. No precharge is issued.
- R4: The column command is read (2) for a request with reqWrite = 0 and write (3) for reqWrite = 1. It carries the request's column on cmdCol and the request's row on cmdRow.
- R5: A request whose row differs from the open row produces exactly three commands. They are, in order: precharge with cmdRow equal to the old open row, activate with the new row, and the column command.
- R6: After a column command the row stays open. A following request to the same row produces exactly one command, the column command.
- R7: cmdValid is high only in cycles where bankReady is high, and each high cycle issues one command. While bankReady is low, the pending command waits and its fields are kept.
- R8: reqReady is high exactly when no command of an accepted request is pending. It drops in the cycle after acceptance and returns in the cycle after the last command of the chain has been issued.
- R9: lastHit is loaded when a request is accepted: 1 for a hit on the open row, 0 for a miss or when no row is open. It holds its value between acceptances.
- R10: cmdBank always equals the BANK_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqRow | input | ROW_W | Request row address |
| reqCol | input | COL_W | Request column address |
| bankReady | input | 1 | Timing tracker allows a command to this bank this cycle |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdCode | output | 2 | Command code (0 PRE, 1 ACT, 2 RD, 3 WR) |
| cmdBank | output | BANK_W | Bank field of the command |
| cmdRow | output | ROW_W | Row field of the command |
| cmdCol | output | COL_W | Column field of the command |
| lastHit | output | 1 | Sticky hit/miss result of the latest accepted request |

## Verification
The hardest case to reach is a precharge or activate that is held for several cycles by a low bankReady while the next request is already waiting on reqValid. Only in that case do stalled command fields, the chain order and the ready timing interact. The stimulus keeps reqValid asserted back to back and switches bankReady to a pseudo-random pattern. It also draws rows from a set of only four values, so hits, misses and stalled chains are all frequent. A reset applied partway through the run then brings back the cold-bank case, so the activate-only chain is exercised a second time after rows have been open.

// File: rtl/bank_seq_pkg.sv
`timescale 1ns/1ps
package bank_seq_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // request accepted this cycle
    logic openLoad;  // activate issued this cycle: new row becomes open
    logic selAct;    // activate phase
    logic selCol;    // column phase
  } seq_strobe_t;
endpackage

// File: rtl/bank_seq_ctrl.sv
`timescale 1ns/1ps
module bank_seq_ctrl
  import bank_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hitNow,
  input  logic        rowOpen,
  input  logic        bankReady,
  output logic        reqReady,
  output logic        cmdValid,
  output seq_strobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_COL} state_e;
  state_e stateQ, stateD;
  logic   accept;

  always_comb begin
    reqReady = (stateQ == S_IDLE);
    accept   = reqValid && reqReady;
    cmdValid = (stateQ != S_IDLE) && bankReady;
    strobe.latchReq = accept;
    strobe.openLoad = (stateQ == S_ACT) && bankReady;
    strobe.selAct   = (stateQ == S_ACT);
    strobe.selCol   = (stateQ == S_COL);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (accept) begin
        if (hitNow)       stateD = S_COL;
        else if (rowOpen) stateD = S_PRE;
        else              stateD = S_ACT;
      end
      S_PRE:  if (bankReady) stateD = S_ACT;
      S_ACT:  if (bankReady) stateD = S_COL;
      S_COL:  if (bankReady) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end
endmodule

// File: rtl/bank_seq_dp.sv
`timescale 1ns/1ps
module bank_seq_dp
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      strobe,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  output logic             hitNow,
  output logic             rowOpen,
  output logic [1:0]       cmdCode,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             lastHit
);
  logic [ROW_W-1:0] reqRowQ, openRowQ;
  logic [COL_W-1:0] reqColQ;
  logic             reqWriteQ, rowValidQ, lastHitQ;

  assign hitNow  = rowValidQ && (reqRow == openRowQ);
  assign rowOpen = rowValidQ;
  assign lastHit = lastHitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqRowQ   <= '0;
      reqColQ   <= '0;
      reqWriteQ <= 1'b0;
      lastHitQ  <= 1'b0;
      openRowQ  <= '0;
      rowValidQ <= 1'b0;
    end else begin
      if (strobe.latchReq) begin
        reqRowQ   <= reqRow;
        reqColQ   <= reqCol;
        reqWriteQ <= reqWrite;
        lastHitQ  <= hitNow;
      end
      if (strobe.openLoad) begin
        openRowQ  <= reqRowQ;
        rowValidQ <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_e code;
    if (strobe.selAct)      code = CMD_ACT;
    else if (strobe.selCol) code = reqWriteQ ? CMD_WR : CMD_RD;
    else                    code = CMD_PRE;
    cmdCode = code;
    cmdRow  = (strobe.selAct || strobe.selCol) ? reqRowQ : openRowQ;
    cmdCol  = reqColQ;
  end
endmodule

// File: rtl/bank_cmd_sequencer.sv
`timescale 1ns/1ps
module bank_cmd_sequencer
  import bank_seq_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 3,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              bankReady,
  output logic              cmdValid,
  output logic [1:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              lastHit
);
  localparam logic [BANK_W-1:0] BANK_VAL = BANK_W'(BANK_ID);

  seq_strobe_t strobe;
  logic        hitNow, rowOpen;

  assign cmdBank = BANK_VAL;

  bank_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hitNow(hitNow),
    .rowOpen(rowOpen), .bankReady(bankReady), .reqReady(reqReady),
    .cmdValid(cmdValid), .strobe(strobe)
  );

  bank_seq_dp #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqRow(reqRow), .reqCol(reqCol), .hitNow(hitNow), .rowOpen(rowOpen),
    .cmdCode(cmdCode), .cmdRow(cmdRow), .cmdCol(cmdCol), .lastHit(lastHit)
  );
endmodule

// File: rtl/bank_seq_checker.sv
`timescale 1ns/1ps
module bank_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       bankReady,
  input logic       cmdValid,
  input logic [1:0] cmdCode,
  input logic       lastHit
);
  logic [1:0] lastIssuedQ;
  logic       issuedAnyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastIssuedQ <= 2'd0;
      issuedAnyQ  <= 1'b0;
    end else if (cmdValid) begin
      lastIssuedQ <= cmdCode;
      issuedAnyQ  <= 1'b1;
    end
  end

  a_r7_cmd_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> bankReady);

  a_r8_idle_no_cmd: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !cmdValid);

  a_r8_accept_closes: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  a_r8_col_reopens: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode[1]) |=> reqReady);

  a_r3_act_follows_pre: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 2'd1 && issuedAnyQ) |-> (lastIssuedQ == 2'd0));

  a_r5_pre_after_col: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == 2'd0) |-> (issuedAnyQ && lastIssuedQ[1]));

  a_r4_col_after_open: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode[1]) |-> (issuedAnyQ && lastIssuedQ != 2'd0));

  a_r9_hit_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> $stable(lastHit));
endmodule

bind bank_cmd_sequencer bank_seq_checker u_seqChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .bankReady(bankReady), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .lastHit(lastHit)
);

// File: tb/test_bank_cmd_sequencer.sv
`timescale 1ns/1ps
module test_bank_cmd_sequencer;
  localparam int ROW_W = 14, COL_W = 10, BANK_W = 3, BANK_ID = 5;

  logic clk, rstN, reqValid, reqReady, reqWrite, bankReady, cmdValid, lastHit;
  logic [ROW_W-1:0]  reqRow, cmdRow;
  logic [COL_W-1:0]  reqCol, cmdCol;
  logic [1:0]        cmdCode;
  logic [BANK_W-1:0] cmdBank;

  bank_cmd_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .BANK_ID(BANK_ID))
    i_bank_cmd_sequencer (
      .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
      .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol), .bankReady(bankReady),
      .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow),
      .cmdCol(cmdCol), .lastHit(lastHit));

  typedef struct {
    logic [1:0]       code;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    string            tag;
  } exp_t;

  exp_t             expQ[$];
  bit               mRowValid, mLastHit;
  logic [ROW_W-1:0] mOpenRow;
  int               tests = 0, fails = 0;
  bit               stallMode = 0;
  bit               done = 0;

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, evaluated between edges
  always @(negedge clk) begin
    if (!rstN) begin
      expQ.delete();
      mRowValid = 0;
      mLastHit  = 0;
      chk(reqReady == 1'b1, "R1 reqReady in reset", 32'(reqReady), 32'd1);
      chk(cmdValid == 1'b0, "R1 cmdValid in reset", 32'(cmdValid), 32'd0);
      chk(lastHit == 1'b0, "R1 lastHit in reset", 32'(lastHit), 32'd0);
    end else begin
      bit expReady, expValid;
      expReady = (expQ.size() == 0);
      expValid = !expReady && bankReady;
      chk(reqReady == expReady, "R8 reqReady", 32'(reqReady), 32'(expReady));
      chk(cmdValid == expValid, "R7 cmdValid", 32'(cmdValid), 32'(expValid));
      chk(lastHit == mLastHit, "R9 lastHit", 32'(lastHit), 32'(mLastHit));
      chk(cmdBank == BANK_W'(BANK_ID), "R10 cmdBank", 32'(cmdBank), 32'(BANK_ID));
      if (!expReady) begin
        // fields of the pending command are shown even while stalled (R7)
        chk(cmdCode == expQ[0].code, {expQ[0].tag, " R2 cmdCode"}, 32'(cmdCode), 32'(expQ[0].code));
        chk(cmdRow == expQ[0].row, {expQ[0].tag, " cmdRow"}, 32'(cmdRow), 32'(expQ[0].row));
        if (expQ[0].code[1])
          chk(cmdCol == expQ[0].col, "R4 cmdCol", 32'(cmdCol), 32'(expQ[0].col));
      end
      if (expValid) void'(expQ.pop_front());
      if (reqValid && expReady) begin
        logic [1:0] colCode;
        colCode = reqWrite ? 2'd3 : 2'd2;  // R4
        if (mRowValid && reqRow == mOpenRow) begin
          mLastHit = 1;                     // R6 hit
          expQ.push_back('{colCode, reqRow, reqCol, "R6"});
        end else if (!mRowValid) begin
          mLastHit = 0;                     // R3 cold bank
          expQ.push_back('{2'd1, reqRow, reqCol, "R3"});
          expQ.push_back('{colCode, reqRow, reqCol, "R3"});
        end else begin
          mLastHit = 0;                     // R5 conflict
          expQ.push_back('{2'd0, mOpenRow, reqCol, "R5"});
          expQ.push_back('{2'd1, reqRow, reqCol, "R5"});
          expQ.push_back('{colCode, reqRow, reqCol, "R5"});
        end
        mRowValid = 1;
        mOpenRow  = reqRow;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    bankReady <= stallMode ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic send(bit w, int row, int col);
    reqValid = 1;
    reqWrite = w;
    reqRow   = ROW_W'(row);
    reqCol   = COL_W'(col);
    do @(negedge clk); while (!reqReady);
    @(posedge clk);
    #1;
    reqValid = 0;
    reqRow   = ROW_W'($urandom);  // don't-care while idle
  endtask

  task automatic drain();
    repeat (2) @(posedge clk);
    while (!reqReady) @(posedge clk);
    #1;
  endtask

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqRow = '0; reqCol = '0; bankReady = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    send(0, 5, 1);   // cold read: ACT, RD
    send(0, 5, 2);   // hit read
    send(1, 5, 3);   // hit write
    send(1, 9, 4);   // conflict write
    send(0, 5, 5);   // conflict read
    drain();
    repeat (3) @(posedge clk);
    #1;
    stallMode = 1;
    for (int i = 0; i < 300; i++)
      send($urandom % 2 == 1, int'($urandom % 4), int'($urandom % 1024));
    drain();
    // reset while rows are open, then cold bank again
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    send(1, 3, 7);
    send(1, 3, 8);
    send(0, 2, 9);
    drain();
    repeat (4) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule